// File: doc/BRIEF.md
# Vectored Sixteen-Channel Interrupt Sequencer

This block delivers vectored interrupts to a macroinstruction emulator. Device logic raises requests at any time by pulsing bits on `set_req`. Each pulse is ORed into a sixteen-bit pending register. A request can only be taken at a macroinstruction start, which the emulator marks with a one-cycle `boundary` strobe. Delivery also needs the global enable to be on and the request's channel to be set in the per-channel `active_mask`.

When an interrupt is taken, the block runs a short sequence on a simple memory handshake. It first writes the emulator's current program counter to a fixed save slot. It then reads the handler address from a sixteen-word vector table at a fixed base, picking the word for the winning channel. Finally it pulses `pc_load` with the new program counter. A return command reads the save slot back and hands that value to the emulator in the same way. Separate command strobes turn the global enable on and off. The emulator stalls while `busy` is high.

Top module: `irq_vector_seq`

## Requirements
- R1: A one-cycle pulse on bit i of `set_req` sets bit i of `pending` on the next cycle. Pulses ORed in on different cycles accumulate. A pending bit stays set until its channel's vector is fetched.
- R2: An interrupt starts only on a cycle where all of these hold: `boundary` is high, `busy` is low, `irq_en` is 1, and `pending & active_mask` is nonzero. In any other case no memory request is made.
- R3: When several channels are eligible, the highest-numbered one is serviced. A request that arrives in the same cycle as `boundary` is not considered for that boundary.
- R4: Taking an interrupt makes two memory requests, each holding until `mem_ack`. The first is a write (`mem_we`=1) of the `cur_pc` sampled at the boundary, to address SAVE_ADDR. The second is a read (`mem_we`=0) from address VEC_BASE plus the channel number.
- R5: In the cycle after the vector read is acknowledged, `pc_load` is high for exactly one cycle and `pc_new` equals the data that was read. The serviced channel's pending bit is cleared.
- R6: Taking an interrupt clears `irq_en` and sets `in_service`. While `irq_en` is 0, further boundaries take nothing.
- R7: `cmd_enable` sets `irq_en` and `cmd_disable` clears it. If both are high in the same cycle, disable wins. Both commands are ignored while `busy` is high.
- R8: `cmd_return` while idle reads address SAVE_ADDR, then pulses `pc_load` with the value read. It also sets `irq_en` and clears `in_service`. If `cmd_return` and a boundary arrive in the same cycle, the return wins and no save write is made.
- R9: After reset, `pending`, `irq_en`, `in_service`, `mem_req`, `pc_load` and `busy` are all 0.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | NCH | Request bits ORed into the pending register |
| active_mask | input | NCH | Per-channel active mask |
| cmd_enable | input | 1 | Enable-interrupts command strobe |
| cmd_disable | input | 1 | Disable-interrupts command strobe |
| cmd_return | input | 1 | Return-from-interrupt command strobe |
| boundary | input | 1 | Macroinstruction start strobe |
| cur_pc | input | W | Emulator program counter at the boundary |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Memory word address |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | W | Read data, valid with the acknowledge |
| pc_load | output | 1 | One-cycle strobe that loads the new program counter |
| pc_new | output | W | New program counter |
| busy | output | 1 | Sequence in progress; emulator stalls |
| irq_en | output | 1 | Global interrupt enable |
| in_service | output | 1 | An interrupt handler is running |
| pending | output | NCH | Pending request bits |

## Verification
The assertions check several properties on every cycle:
- requests accumulate in `pending`;
- memory requests appear only while `busy` is high and stay stable until acknowledged;
- every save write targets the save slot, and every read that is not a return lands inside the vector table;
- a save write starts only one cycle after a boundary, and only while the enable is off;
- `pc_load` never lasts more than one cycle.

Only the bench's scenarios can show the rest: which channel wins, which data moves through the save slot and back on return, that a request in the same cycle as a boundary is deferred, that commands are ignored while busy, and that a return has priority over a boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_VEC   = 3'd2,
    ST_RLOAD = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_req,
  input  logic           clr_en,
  input  logic [CW-1:0]  clr_idx,
  output logic [NCH-1:0] pending_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_en && (clr_idx == CW'(i));
    always_ff @(posedge clk) begin
      if (rst) pending_q[i] <= 1'b0;
      else     pending_q[i] <= (pending_q[i] && !clr_hit) || set_req[i];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] elig,
  output logic           any,
  output logic [CW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i]) idx = CW'(i);
    end
    any = |elig;
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int W = 16,
  parameter logic [W-1:0] SAVE_ADDR = 16'h0010,
  parameter logic [W-1:0] VEC_BASE  = 16'h0020,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_any,
  input  logic [CW-1:0] take_idx,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          cmd_return,
  input  logic          boundary,
  input  logic [W-1:0]  cur_pc,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          pc_load,
  output logic [W-1:0]  pc_new,
  output logic          busy,
  output logic          irq_en,
  output logic          in_service,
  output logic          clr_en,
  output logic [CW-1:0] clr_idx
);
  seq_state_t    state;
  logic [CW-1:0] chan_q;

  assign busy    = (state != ST_IDLE);
  assign clr_en  = (state == ST_VEC) && mem_ack;
  assign clr_idx = chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      irq_en     <= 1'b0;
      in_service <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      pc_load    <= 1'b0;
      pc_new     <= '0;
      chan_q     <= '0;
    end else begin
      pc_load <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_return) begin
            state    <= ST_RLOAD;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= SAVE_ADDR;
          end else if (boundary && irq_en && take_any) begin
            state      <= ST_SAVE;
            mem_req    <= 1'b1;
            mem_we     <= 1'b1;
            mem_addr   <= SAVE_ADDR;
            mem_wdata  <= cur_pc;
            chan_q     <= take_idx;
            irq_en     <= 1'b0;
            in_service <= 1'b1;
          end else if (cmd_disable) begin
            irq_en <= 1'b0;
          end else if (cmd_enable) begin
            irq_en <= 1'b1;
          end
        end
        ST_SAVE: begin
          if (mem_ack) begin
            state    <= ST_VEC;
            mem_we   <= 1'b0;
            mem_addr <= VEC_BASE + W'(chan_q);
          end
        end
        ST_VEC: begin
          if (mem_ack) begin
            state   <= ST_DONE;
            mem_req <= 1'b0;
            pc_new  <= mem_rdata;
            pc_load <= 1'b1;
          end
        end
        ST_RLOAD: begin
          if (mem_ack) begin
            state      <= ST_DONE;
            mem_req    <= 1'b0;
            pc_new     <= mem_rdata;
            pc_load    <= 1'b1;
            irq_en     <= 1'b1;
            in_service <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter int NCH = 16,
  parameter int W = 16,
  parameter logic [W-1:0] SAVE_ADDR = 16'h0010,
  parameter logic [W-1:0] VEC_BASE  = 16'h0020
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_req,
  input  logic [NCH-1:0] active_mask,
  input  logic           cmd_enable,
  input  logic           cmd_disable,
  input  logic           cmd_return,
  input  logic           boundary,
  input  logic [W-1:0]   cur_pc,
  output logic           mem_req,
  output logic           mem_we,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic           mem_ack,
  input  logic [W-1:0]   mem_rdata,
  output logic           pc_load,
  output logic [W-1:0]   pc_new,
  output logic           busy,
  output logic           irq_en,
  output logic           in_service,
  output logic [NCH-1:0] pending
);
  localparam int CW = $clog2(NCH);

  logic          clr_en;
  logic [CW-1:0] clr_idx;
  logic          take_any;
  logic [CW-1:0] take_idx;
  logic [NCH-1:0] elig;

  assign elig = pending & active_mask;

  irq_pending_reg #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst), .set_req(set_req),
    .clr_en(clr_en), .clr_idx(clr_idx), .pending_q(pending)
  );

  irq_prio_pick #(.NCH(NCH)) u_pick (
    .elig(elig), .any(take_any), .idx(take_idx)
  );

  irq_seq_ctrl #(.NCH(NCH), .W(W), .SAVE_ADDR(SAVE_ADDR), .VEC_BASE(VEC_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .take_any(take_any), .take_idx(take_idx),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_return(cmd_return),
    .boundary(boundary), .cur_pc(cur_pc), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_load(pc_load), .pc_new(pc_new), .busy(busy), .irq_en(irq_en),
    .in_service(in_service), .clr_en(clr_en), .clr_idx(clr_idx)
  );
endmodule

// File: rtl/irq_vector_seq_chk.sv
module irq_vector_seq_chk #(
  parameter int NCH = 16,
  parameter int W = 16,
  parameter logic [W-1:0] SAVE_ADDR = 16'h0010,
  parameter logic [W-1:0] VEC_BASE  = 16'h0020
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] set_req,
  input logic           boundary,
  input logic           mem_req,
  input logic           mem_we,
  input logic [W-1:0]   mem_addr,
  input logic           mem_ack,
  input logic           pc_load,
  input logic           busy,
  input logic           irq_en,
  input logic           in_service,
  input logic [NCH-1:0] pending
);
  localparam logic [W-1:0] NCH_W = W'(NCH);

  AST_PEND_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (|set_req) |=> ((pending & $past(set_req)) == $past(set_req))); // R1
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R2
  AST_SAVE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(boundary) && !irq_en && in_service)); // R6
  AST_SAVE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr == SAVE_ADDR)); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_addr != SAVE_ADDR) |-> ((mem_addr - VEC_BASE) < NCH_W)); // R4
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R10
endmodule

bind irq_vector_seq irq_vector_seq_chk #(
  .NCH(NCH), .W(W), .SAVE_ADDR(SAVE_ADDR), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .set_req(set_req), .boundary(boundary),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .pc_load(pc_load), .busy(busy), .irq_en(irq_en), .in_service(in_service),
  .pending(pending)
);

// File: tb/sim_irq_vector_seq.sv
`timescale 1ns/1ps
module sim_irq_vector_seq;
  localparam int NCH = 16;
  localparam int W = 16;
  localparam logic [W-1:0] SAVE_A = 16'h0010;
  localparam logic [W-1:0] VBASE  = 16'h0020;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] set_req = '0, active_mask = '0, pending;
  logic cmd_enable = 0, cmd_disable = 0, cmd_return = 0, boundary = 0;
  logic [W-1:0] cur_pc = '0, mem_addr, mem_wdata, pc_new;
  logic [W-1:0] mem_rdata = '0;
  logic mem_req, mem_we, mem_ack = 0, pc_load, busy, irq_en, in_service;

  always #2.5 clk = ~clk;

  irq_vector_seq #(.NCH(NCH), .W(W), .SAVE_ADDR(SAVE_A), .VEC_BASE(VBASE)) u0 (
    .clk(clk), .rst(rst), .set_req(set_req), .active_mask(active_mask),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_return(cmd_return),
    .boundary(boundary), .cur_pc(cur_pc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_new(pc_new), .busy(busy),
    .irq_en(irq_en), .in_service(in_service), .pending(pending)
  );

  int checks = 0, fails = 0;
  int lat = 1, cnt = 0;
  int acc_cnt = 0, wr_cnt = 0, loads = 0;
  logic [W-1:0] mem [0:255];
  logic [W-1:0] last_wr_addr, last_wr_data, last_rd_addr, last_pc;

  function automatic logic [W-1:0] vec_of(int ch);
    return 16'h4000 + W'(ch * 16'h0010);
  endfunction

  // memory model and load monitor
  always @(negedge clk) begin
    if (pc_load) begin loads++; last_pc = pc_new; end
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && !rst) begin
      cnt++;
      if (cnt >= lat) begin
        cnt = 0;
        acc_cnt++;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[7:0]] = mem_wdata;
          wr_cnt++; last_wr_addr = mem_addr; last_wr_data = mem_wdata;
          mem_rdata <= '0;
        end else begin
          last_rd_addr = mem_addr;
          mem_rdata <= mem[mem_addr[7:0]];
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_boundary(logic [W-1:0] pc);
    boundary = 1; cur_pc = pc;
    @(negedge clk);
    boundary = 0;
  endtask

  task automatic wait_load(int prev);
    for (int i = 0; i < 200 && loads <= prev; i++) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9", "pending", pending, 0);
    chk("R9", "irq_en", irq_en, 0);
    chk("R9", "in_service", in_service, 0);
    chk("R9", "mem_req", mem_req, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "pc_load", pc_load, 0);
  endtask

  task automatic t_accum();
    set_req = 16'h0001; @(negedge clk);
    set_req = 16'h0100; @(negedge clk);
    set_req = 16'h0000;
    chk("R1", "pending accumulate", pending, 16'h0101);
    active_mask = 16'hFFFF;
    pulse_boundary(16'h0BAD);
    idle(6);
    chk("R2", "no access when disabled", acc_cnt, 0);
    chk("R2", "busy when disabled", busy, 0);
  endtask

  task automatic t_masked();
    cmd_enable = 1; @(negedge clk); cmd_enable = 0;
    chk("R7", "enable sets irq_en", irq_en, 1);
    active_mask = 16'h0002;
    pulse_boundary(16'h0BAD);
    idle(6);
    chk("R2", "masked channel not taken", acc_cnt, 0);
    active_mask = 16'hFFFF;
    idle(6);
    chk("R2", "no take without boundary", acc_cnt, 0);
  endtask

  task automatic t_take();
    int l0 = loads;
    lat = 2;
    pulse_boundary(16'h1234);
    wait_load(l0);
    chk("R4", "save address", last_wr_addr, SAVE_A);
    chk("R4", "saved pc", last_wr_data, 16'h1234);
    chk("R3", "vector addr of highest ch8", last_rd_addr, VBASE + 16'd8);
    chk("R5", "pc_new is vector", last_pc, vec_of(8));
    chk("R5", "ch8 pending cleared", pending, 16'h0001);
    chk("R6", "irq_en cleared", irq_en, 0);
    chk("R6", "in_service set", in_service, 1);
    chk("R4", "two accesses", acc_cnt, 2);
    @(negedge clk);
    chk("R5", "pc_load single cycle", pc_load, 0);
  endtask

  task automatic t_no_reenter();
    int a0 = acc_cnt;
    pulse_boundary(16'h5555);
    idle(6);
    chk("R6", "no take while disabled", acc_cnt, a0);
  endtask

  task automatic t_return(logic [W-1:0] exp_pc);
    int l0 = loads;
    int w0 = wr_cnt;
    lat = 3;
    cmd_return = 1; @(negedge clk); cmd_return = 0;
    wait_load(l0);
    chk("R8", "return pc", last_pc, exp_pc);
    chk("R8", "return read addr", last_rd_addr, SAVE_A);
    chk("R8", "irq_en set", irq_en, 1);
    chk("R8", "in_service cleared", in_service, 0);
    chk("R8", "no write on return", wr_cnt, w0);
  endtask

  task automatic t_late_req_and_busy_cmd();
    int l0 = loads;
    lat = 4;
    set_req = 16'h8000;
    pulse_boundary(16'h2222);
    set_req = 16'h0000;
    cmd_enable = 1; @(negedge clk); cmd_enable = 0;
    wait_load(l0);
    chk("R3", "same-cycle request deferred", last_rd_addr, VBASE);
    chk("R5", "ch0 vector", last_pc, vec_of(0));
    chk("R5", "ch0 cleared", pending, 16'h8000);
    chk("R7", "enable ignored while busy", irq_en, 0);
  endtask

  task automatic t_return_wins();
    int l0 = loads;
    int w0 = wr_cnt;
    irq_en_force();
    cmd_return = 1; boundary = 1; cur_pc = 16'h7777;
    @(negedge clk);
    cmd_return = 0; boundary = 0;
    wait_load(l0);
    chk("R8", "return beats boundary, no write", wr_cnt, w0);
    chk("R8", "return pc", last_pc, 16'h2222);
    chk("R1", "pending kept", pending, 16'h8000);
  endtask

  task automatic irq_en_force();
    cmd_enable = 1; @(negedge clk); cmd_enable = 0;
  endtask

  task automatic t_disable_wins();
    int a0;
    cmd_enable = 1; cmd_disable = 1; @(negedge clk);
    cmd_enable = 0; cmd_disable = 0;
    chk("R7", "disable wins", irq_en, 0);
    a0 = acc_cnt;
    pulse_boundary(16'h3333);
    idle(6);
    chk("R7", "no take after disable", acc_cnt, a0);
  endtask

  task automatic t_top_channel();
    int l0;
    irq_en_force();
    l0 = loads;
    lat = 1;
    pulse_boundary(16'h4444);
    wait_load(l0);
    chk("R3", "channel 15 vector addr", last_rd_addr, VBASE + 16'd15);
    chk("R5", "channel 15 vector", last_pc, vec_of(15));
    chk("R1", "pending empty", pending, 16'h0000);
    chk("R4", "save data", mem[SAVE_A[7:0]], 16'h4444);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < NCH; i++) mem[VBASE[7:0] + i] = vec_of(i);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_accum();
    t_masked();
    t_take();
    t_no_reenter();
    t_return(16'h1234);
    t_late_req_and_busy_cmd();
    t_return_wins();
    t_disable_wins();
    t_top_channel();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule